// File: doc/BRIEF.md
# PMIC Bus Command Channel

This block is one register-mapped command channel of a serial master for a power-management bus. Software first loads up to two 32-bit data words. It then writes a command word that starts exactly one bus transaction. The channel passes the transaction to a bus engine through a valid/ready request and takes back a single-cycle response. On completion it posts done and outcome flags in a status word. For read-type commands it returns up to eight bytes in two read-data words.

The channel holds at most one transaction at a time. The transaction's opcode, slave id, address, byte count and write data are captured when the command is accepted. Software may therefore reload the data words while the transaction is in progress. A command written while the channel is busy is discarded. The completing transaction then reports it as dropped. The decision to deny a transaction is made outside the block and arrives with the response.

Top module: `pmic_cmd_channel`

## Requirements
- R1: A write to offset 0x00 while idle starts a transaction. The next cycle `req_valid` rises with opcode = word[31:27], slave id = word[23:20], address = word[19:4] and byte count minus one = word[2:0]. All request fields hold steady until a cycle with `req_ready` high.
- R2: The data words at offset 0x10 (bytes 0..3) and offset 0x14 (bytes 4..7) read back as written. Their values at command acceptance appear on `req_wdata` as {word at 0x14, word at 0x10}, with byte 0 in the least significant bits.
- R3: For the non-data opcodes 3, 4, 5 and 6, the request carries address 0 and byte count 0, whatever those fields of the command word held.
- R4: The status word at offset 0x08 uses bit 0 = done, bit 1 = failure, bit 2 = denied and bit 3 = dropped. An accepted command clears it to zero. The response cycle loads {dropped, `rsp_denied`, `rsp_fail`, 1} into it.
- R5: A read-type transaction (opcode 1, 8, 13 or 15) that completes with neither failure nor denial loads `rsp_rdata` into offset 0x18 (bytes 0..3) and offset 0x1C (bytes 4..7). Every byte above the byte count reads as zero.
- R6: The read-data words do not change on write-type or non-data completions, on failed or denied reads, or on software writes to their offsets.
- R7: A command written while a transaction is in progress starts no new request and does not alter the current one. The completion status of the current transaction has the dropped bit set.
- R8: The word at offset 0x04 is a read/write configuration word. Every unmapped offset reads as zero, and writes to unmapped offsets have no effect.
- R9: After reset, every register reads zero and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte offset inside the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| req_valid | output | 1 | Transaction request pending |
| req_ready | input | 1 | Bus engine takes the request |
| req_opcode | output | 5 | Requested opcode |
| req_sid | output | 4 | Requested slave id |
| req_addr | output | 16 | Requested register address |
| req_bc | output | 3 | Requested byte count minus one |
| req_wdata | output | 64 | Write bytes 0..7, byte 0 lowest |
| rsp_valid | input | 1 | Single-cycle completion from the bus engine |
| rsp_fail | input | 1 | Transaction failed on the bus |
| rsp_denied | input | 1 | Transaction refused by access policy |
| rsp_rdata | input | 64 | Read bytes 0..7, byte 0 lowest |

## Verification
The dropped-command case is the hardest to reach from the ports. A second command has to arrive while the first is still waiting for `req_ready`, or while it is waiting for its response. The first transaction's request must then stay unchanged and no second request may follow. The bench acts as the bus engine and controls both handshakes itself. It inserts the extra command write in each of the two waiting phases, and also in the very cycle the response arrives. It then checks the request fields, the idle request line and the dropped bit. Byte masking is swept over every byte count for every read opcode.

// File: rtl/pcc_pkg.sv
// Package: shared constants, types and opcode classifiers for the command channel.
// Assumes a 32-bit register word and a 64-bit (8-byte) transaction payload.
package pcc_pkg;
    localparam int WORD_W  = 32;
    localparam int OFS_W   = 7;
    localparam int LANES   = 8;
    localparam int BC_W    = $clog2(LANES);
    localparam int PAY_W   = LANES * 8;

    localparam logic [OFS_W-1:0] OFS_CMD  = 7'h00;
    localparam logic [OFS_W-1:0] OFS_CFG  = 7'h04;
    localparam logic [OFS_W-1:0] OFS_STAT = 7'h08;
    localparam logic [OFS_W-1:0] OFS_WD0  = 7'h10;
    localparam logic [OFS_W-1:0] OFS_WD1  = 7'h14;
    localparam logic [OFS_W-1:0] OFS_RD0  = 7'h18;
    localparam logic [OFS_W-1:0] OFS_RD1  = 7'h1C;

    localparam logic [4:0] OPC_XRD_LONG = 5'd1;
    localparam logic [4:0] OPC_BUS_RST  = 5'd3;
    localparam logic [4:0] OPC_BUS_WAKE = 5'd6;
    localparam logic [4:0] OPC_HOST_RD  = 5'd8;
    localparam logic [4:0] OPC_XRD      = 5'd13;
    localparam logic [4:0] OPC_RD       = 5'd15;

    typedef struct packed {
        logic [4:0]      opc;
        logic [3:0]      sid;
        logic [15:0]     addr;
        logic [BC_W-1:0] bc;
    } xact_t;

    typedef struct packed {
        logic dropped;
        logic denied;
        logic fail;
        logic done;
    } stat_t;

    function automatic logic op_is_ctrl(input logic [4:0] opc);
        return (opc >= OPC_BUS_RST) && (opc <= OPC_BUS_WAKE);
    endfunction

    function automatic logic op_is_read(input logic [4:0] opc);
        return (opc == OPC_XRD_LONG) || (opc == OPC_HOST_RD) ||
               (opc == OPC_XRD) || (opc == OPC_RD);
    endfunction

    // Splits a command word into request fields; control opcodes lose address and count.
    function automatic xact_t decode_cmd(input logic [WORD_W-1:0] w);
        xact_t x;
        x.opc  = w[31:27];
        x.sid  = w[23:20];
        x.addr = op_is_ctrl(w[31:27]) ? 16'h0 : w[19:4];
        x.bc   = op_is_ctrl(w[31:27]) ? '0 : w[BC_W-1:0];
        return x;
    endfunction
endpackage

// File: rtl/pcc_rdmask.sv
// Module: zeroes every read byte whose lane index is above the byte count.
// Assumes lane 0 sits in the least significant byte of the payload.
module pcc_rdmask #(
    parameter int LANES = 8,
    localparam int BC_W = $clog2(LANES)
) (
    input  logic [BC_W-1:0]    bc,
    input  logic [LANES*8-1:0] raw,
    output logic [LANES*8-1:0] masked
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane g survives only when it lies inside the transfer length.
        assign masked[g*8 +: 8] = (BC_W'(g) <= bc) ? raw[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pcc_seq.sv
// Module: transaction sequencer. It accepts one command at a time, drives the
// request handshake, collects the response and keeps the status flags.
// Assumes the bus engine answers only after it has taken the request.
module pcc_seq
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [PAY_W-1:0]  wd_words,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_fail,
    input  logic              rsp_denied,
    output logic              req_valid,
    output xact_t             req,
    output logic [PAY_W-1:0]  req_wdata,
    output stat_t             stat,
    output logic [WORD_W-1:0] cmd_shadow,
    output logic              rd_load
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;
    seq_e state;
    logic drop_pend;
    logic busy;

    assign busy      = (state != S_IDLE);
    assign req_valid = (state == S_ISSUE);
    // A successful read completion loads the read-data words.
    assign rd_load   = (state == S_WAIT) && rsp_valid && op_is_read(req.opc) &&
                       !rsp_fail && !rsp_denied;

    // Steps the state machine and records the request, status and drop marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            req        <= '0;
            req_wdata  <= '0;
            stat       <= '0;
            cmd_shadow <= '0;
            drop_pend  <= 1'b0;
        end else begin
            if (busy && cmd_wr) drop_pend <= 1'b1;
            case (state)
                S_IDLE: if (cmd_wr) begin
                    req        <= decode_cmd(cmd_word);
                    req_wdata  <= wd_words;
                    cmd_shadow <= cmd_word;
                    stat       <= '0;
                    drop_pend  <= 1'b0;
                    state      <= S_ISSUE;
                end
                S_ISSUE: if (req_ready) state <= S_WAIT;
                S_WAIT: if (rsp_valid) begin
                    stat  <= '{dropped: drop_pend | cmd_wr, denied: rsp_denied,
                               fail: rsp_fail, done: 1'b1};
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1: a pending request keeps all fields until it is taken.
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req) && $stable(req_wdata)));
    // R3: control opcodes never carry address or count.
    p_ctrl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_is_ctrl(req.opc)) |-> (req.addr == 16'h0 && req.bc == '0));
    // R4: acceptance clears the status word.
    p_accept_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr) |=> (stat == '0 && req_valid));
    // R4: done stays low while a transaction is open.
    p_busy_nodone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stat.done);
    // R7: a command written in the completion cycle still marks the result dropped.
    p_late_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && rsp_valid && cmd_wr) |=> (stat.dropped && !req_valid));
endmodule

// File: rtl/pcc_regfile.sv
// Module: software-visible register file with read mux and command strobe.
// Assumes whole-word accesses at word-aligned offsets inside the window.
module pcc_regfile
    import pcc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [OFS_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               cmd_wr,
    output logic [PAY_W-1:0]   wd_words,
    input  logic               rd_load,
    input  logic [PAY_W-1:0]   rd_value,
    input  stat_t              stat,
    input  logic [WORD_W-1:0]  cmd_shadow
);
    logic [WORD_W-1:0] cfg_q, wd0_q, wd1_q, rd0_q, rd1_q;

    assign cmd_wr   = reg_we && (reg_addr == OFS_CMD);
    assign wd_words = {wd1_q, wd0_q};

    // Stores the configuration and write-data words from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            wd0_q <= '0;
            wd1_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFS_CFG) cfg_q <= reg_wdata;
            if (reg_addr == OFS_WD0) wd0_q <= reg_wdata;
            if (reg_addr == OFS_WD1) wd1_q <= reg_wdata;
        end
    end

    // Loads the read-data words on a successful read completion only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0_q <= '0;
            rd1_q <= '0;
        end else if (rd_load) begin
            rd0_q <= rd_value[WORD_W-1:0];
            rd1_q <= rd_value[PAY_W-1:WORD_W];
        end
    end

    // Selects the register addressed by software; unmapped offsets give zero.
    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = cmd_shadow;
            OFS_CFG:  reg_rdata = cfg_q;
            OFS_STAT: reg_rdata = {{(WORD_W-4){1'b0}}, stat};
            OFS_WD0:  reg_rdata = wd0_q;
            OFS_WD1:  reg_rdata = wd1_q;
            OFS_RD0:  reg_rdata = rd0_q;
            OFS_RD1:  reg_rdata = rd1_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: read data holds unless a successful read completes.
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> ($stable(rd0_q) && $stable(rd1_q)));
    // R2: a write-data store is visible on the next cycle.
    p_wd_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_WD0) |=> (wd_words[WORD_W-1:0] == $past(reg_wdata)));
endmodule

// File: rtl/pmic_cmd_channel.sv
// Module: top of one command channel; joins the register file, the sequencer
// and the read-byte mask. Assumes one bus engine serves this channel.
module pmic_cmd_channel
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [4:0]        req_opcode,
    output logic [3:0]        req_sid,
    output logic [15:0]       req_addr,
    output logic [2:0]        req_bc,
    output logic [63:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_fail,
    input  logic              rsp_denied,
    input  logic [63:0]       rsp_rdata
);
    logic              cmd_wr, rd_load;
    logic [PAY_W-1:0]  wd_words, rd_masked;
    logic [WORD_W-1:0] cmd_shadow;
    xact_t             req;
    stat_t             stat;

    assign req_opcode = req.opc;
    assign req_sid    = req.sid;
    assign req_addr   = req.addr;
    assign req_bc     = req.bc;

    pcc_regfile #(.LANES(LANES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
        .wd_words(wd_words), .rd_load(rd_load), .rd_value(rd_masked),
        .stat(stat), .cmd_shadow(cmd_shadow)
    );

    pcc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(reg_wdata),
        .wd_words(wd_words), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_fail(rsp_fail), .rsp_denied(rsp_denied), .req_valid(req_valid),
        .req(req), .req_wdata(req_wdata), .stat(stat),
        .cmd_shadow(cmd_shadow), .rd_load(rd_load)
    );

    pcc_rdmask #(.LANES(LANES)) u_mask (
        .bc(req.bc), .raw(rsp_rdata), .masked(rd_masked)
    );

    // R9: no request is pending in the cycle after reset.
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !req_valid);
endmodule

// File: tb/pmic_cmd_channel_bench.sv
module pmic_cmd_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [4:0]  req_opcode;
    logic [3:0]  req_sid;
    logic [15:0] req_addr;
    logic [2:0]  req_bc;
    logic [63:0] req_wdata;
    logic        rsp_valid = 1'b0, rsp_fail = 1'b0, rsp_denied = 1'b0;
    logic [63:0] rsp_rdata = '0;

    int checks = 0, fails = 0;
    bit done_flag = 0;
    logic [63:0] exp_rd = '0;
    logic [63:0] wd_model = '0;

    always #4 clk = ~clk;

    pmic_cmd_channel u_pmic_cmd_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_opcode(req_opcode), .req_sid(req_sid),
        .req_addr(req_addr), .req_bc(req_bc), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_denied(rsp_denied),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called in the low phase; consumes one rising edge.
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] lane_mask(input logic [2:0] bc);
        logic [63:0] m = '0;
        for (int i = 0; i <= int'(bc); i++) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // drop_at: 0 none, 1 while request pending, 2 while awaiting response, 3 in response cycle.
    task automatic run_txn(input logic [31:0] cw, input bit fl, input bit dn,
                           input logic [63:0] rdat, input int hold, input int drop_at,
                           output logic [31:0] st);
        logic [4:0]  eop  = cw[31:27];
        bit          ctrl = (eop >= 3 && eop <= 6);
        bit          isrd = (eop == 1 || eop == 8 || eop == 13 || eop == 15);
        logic [15:0] eadr = ctrl ? 16'h0 : cw[19:4];
        logic [2:0]  ebc  = ctrl ? 3'd0 : cw[2:0];
        logic [31:0] s;
        wr(7'h00, cw);
        rd(7'h08, s);
        chk(s == 32'h0, "R4 status cleared on accept", {32'h0, s}, 64'h0);
        chk(req_valid == 1'b1, "R1 request raised", {63'h0, req_valid}, 64'h1);
        chk({req_opcode, req_sid} == {eop, cw[23:20]}, "R1 opcode/sid",
            {55'h0, req_opcode, req_sid}, {55'h0, eop, cw[23:20]});
        chk({req_addr, req_bc} == {eadr, ebc}, ctrl ? "R3 control addr/bc zero" : "R1 addr/bc",
            {45'h0, req_addr, req_bc}, {45'h0, eadr, ebc});
        chk(req_wdata == wd_model, "R2 request data", req_wdata, wd_model);
        if (drop_at == 1) begin
            wr(7'h00, ~cw);
            chk(req_valid && {req_opcode, req_sid, req_addr, req_bc} == {eop, cw[23:20], eadr, ebc},
                "R7 pending request unchanged", {35'h0, req_opcode, req_sid, req_addr, req_bc},
                {35'h0, eop, cw[23:20], eadr, ebc});
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(req_valid && req_addr == eadr && req_wdata == wd_model, "R1 request held",
                {47'h0, req_valid, req_addr}, {47'h1, eadr});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (drop_at == 2) wr(7'h00, cw ^ 32'h0800_0005);
        rsp_valid = 1'b1; rsp_fail = fl; rsp_denied = dn; rsp_rdata = rdat;
        if (drop_at == 3) begin reg_we = 1'b1; reg_addr = 7'h00; reg_wdata = cw; end
        @(negedge clk);
        reg_we = 1'b0;
        rsp_valid = 1'b0; rsp_fail = 1'b0; rsp_denied = 1'b0;
        if (isrd && !fl && !dn) exp_rd = rdat & lane_mask(ebc);
        rd(7'h08, st);
        chk(st == {28'h0, drop_at != 0, dn, fl, 1'b1}, drop_at != 0 ? "R7 dropped status" : "R4 completion status",
            {32'h0, st}, {60'h0, drop_at != 0, dn, fl, 1'b1});
        @(negedge clk);
        chk(req_valid == 1'b0, "R7 no extra request", {63'h0, req_valid}, 64'h0);
        rd(7'h18, s);
        chk(s == exp_rd[31:0], isrd ? "R5 read word low" : "R6 read word low unchanged",
            {32'h0, s}, {32'h0, exp_rd[31:0]});
        rd(7'h1C, s);
        chk(s == exp_rd[63:32], isrd ? "R5 read word high" : "R6 read word high unchanged",
            {32'h0, s}, {32'h0, exp_rd[63:32]});
    endtask

    function automatic logic [31:0] mkcmd(input logic [4:0] op, input logic [3:0] sid,
                                          input logic [15:0] a, input logic [2:0] bc);
        return {op, 3'b000, sid, a, 1'b0, bc};
    endfunction

    initial begin
        logic [31:0] v, st;
        logic [4:0] wops [6] = '{5'd0, 5'd2, 5'd14, 5'd16, 5'd9, 5'd7};
        logic [4:0] rops [4] = '{5'd1, 5'd8, 5'd13, 5'd15};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state across every offset.
        for (int a = 0; a < 32; a++) begin
            rd(7'(a * 4), v);
            chk(v == 32'h0, "R9 register zero after reset", {32'h0, v}, 64'h0);
        end
        chk(req_valid == 1'b0, "R9 no request after reset", {63'h0, req_valid}, 64'h0);
        // R8: configuration word and unmapped offsets.
        wr(7'h04, 32'hC3A5_5A3C);
        rd(7'h04, v);
        chk(v == 32'hC3A5_5A3C, "R8 config readback", {32'h0, v}, 64'hC3A5_5A3C);
        wr(7'h0C, 32'hFFFF_FFFF);
        rd(7'h0C, v);
        chk(v == 32'h0, "R8 unmapped reads zero", {32'h0, v}, 64'h0);
        wr(7'h40, 32'h1234_5678);
        rd(7'h40, v);
        chk(v == 32'h0, "R8 unmapped write no effect", {32'h0, v}, 64'h0);
        // R6: software writes to the read-data offsets are ignored.
        wr(7'h18, 32'hDEAD_BEEF);
        wr(7'h1C, 32'hFEED_F00D);
        rd(7'h18, v);
        chk(v == 32'h0, "R6 read word low not writable", {32'h0, v}, 64'h0);
        rd(7'h1C, v);
        chk(v == 32'h0, "R6 read word high not writable", {32'h0, v}, 64'h0);
        // R1 R2: write-type opcodes swept over all byte counts.
        foreach (wops[i]) begin
            for (int bc = 0; bc < 8; bc++) begin
                wd_model = {32'h8000_0000 | 32'(i * 16 + bc), 32'h1000_0000 + 32'(bc * 3)};
                wr(7'h10, wd_model[31:0]);
                wr(7'h14, wd_model[63:32]);
                rd(7'h14, v);
                chk(v == wd_model[63:32], "R2 data word readback", {32'h0, v}, {32'h0, wd_model[63:32]});
                run_txn(mkcmd(wops[i], 4'(bc + i), 16'h1000 * 16'(bc) + 16'(i), 3'(bc)),
                        1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, bc % 3, 0, st);
            end
        end
        // R5: read-type opcodes swept over all byte counts.
        foreach (rops[i]) begin
            for (int bc = 0; bc < 8; bc++) begin
                run_txn(mkcmd(rops[i], 4'(15 - bc), 16'hA500 + 16'(bc), 3'(bc)), 1'b0, 1'b0,
                        64'h8877_6655_4433_2211 ^ {8{8'(i * 8 + bc + 1)}}, 0, 0, st);
            end
        end
        // R3: control opcodes with junk in the address and count fields.
        for (int op = 3; op <= 6; op++)
            run_txn(mkcmd(5'(op), 4'(op), 16'hBEEF, 3'd5), 1'b0, 1'b0, 64'h0, 1, 0, st);
        // R6 R4: failed, denied and combined outcomes on reads.
        run_txn(mkcmd(5'd15, 4'd2, 16'h0042, 3'd7), 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 0, 0, st);
        run_txn(mkcmd(5'd13, 4'd3, 16'h0043, 3'd7), 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 0, 0, st);
        run_txn(mkcmd(5'd1, 4'd4, 16'h0044, 3'd7), 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 2, 0, st);
        // R7: extra commands in each waiting phase.
        for (int d = 1; d <= 3; d++)
            run_txn(mkcmd(5'd15, 4'(d), 16'h7000 + 16'(d), 3'(d + 2)), 1'b0, 1'b0,
                    64'hCAFE_BABE_0BAD_F00D, 1, d, st);
        // R4: the next clean command clears the dropped flag.
        run_txn(mkcmd(5'd14, 4'd9, 16'h0001, 3'd0), 1'b0, 1'b0, 64'h0, 0, 0, st);
        // R9: reset in mid-transaction returns everything to zero.
        wr(7'h00, mkcmd(5'd15, 4'd1, 16'h0002, 3'd1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_valid == 1'b0, "R9 reset clears request", {63'h0, req_valid}, 64'h0);
        rd(7'h18, v);
        chk(v == 32'h0, "R9 reset clears read data", {32'h0, v}, 64'h0);
        rd(7'h04, v);
        chk(v == 32'h0, "R9 reset clears config", {32'h0, v}, 64'h0);
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 1'b0, 1'b1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule